// File: doc/BRIEF.md
# SCL Divisor Pair Search Engine

This block works out the two divisor settings for a two-stage bus clock prescaler. Given the frequency of its input clock and a requested serial clock rate, it picks a 2-bit first-stage divisor `A` and a 6-bit second-stage divisor `B`. The resulting clock is `fin / (22 * (A+1) * (B+1))`.

A request is accepted with a one-cycle `start` pulse while the block is idle. The block then runs a fixed search. It performs a sequence of integer divisions on one shared iterative divider. For each of the four `A` values it derives the smallest `B` that keeps the output at or below the request. It then keeps the candidate that lands closest to the request. The answer appears together with a one-cycle `done` pulse and stays on the outputs until the next answer.

A request that cannot be served raises `err` and returns zero divisors. This covers a rate of zero, a rate above the supported 400 kHz, a prescale ratio out of range, or a search that finds no candidate. Programming the divisors into a controller is left to the surrounding logic.

Top module: `scl_div_search`

## Requirements
- R1: After reset `busy`, `done`, `err`, `div_a`, `div_b` and `fout` are all zero.
- R2: A `start` seen while idle raises `busy` in the next cycle. Each search ends with `done` high for exactly one cycle, with `busy` low in that cycle.
- R3: A requested rate of 0 or above 400000 ends the search with `err` = 1.
- R4: If `floor(fin / (22 * freq_req))` is 0 or greater than 256, the search ends with `err` = 1.
- R5: For each A from 0 to 3 in ascending order, the block forms Bc = ceil(fin / (22 * freq_req * (A+1))).
  - A candidate is skipped when Bc < 1 or Bc > 64.
  - Otherwise its achieved rate is floor(fin / (22 * (A+1) * Bc)), and it is dropped if that rate exceeds `freq_req`.
  - Among the survivors, the one with the smallest `freq_req - achieved` wins, and a tie keeps the lower A.
  - The winner is reported as `div_a` = A, `div_b` = Bc - 1 and `fout` = achieved rate, with `err` = 0.
- R6: When no candidate survives, `err` = 1. Whenever `err` = 1 at `done`, `div_a`, `div_b` and `fout` are zero.
- R7: With `err` = 0 at `done`, `fout <= freq_req` and `fout * 22 * (div_a+1) * (div_b+1) <= fin` for the captured request.
- R8: A `start` that arrives while `busy` is high is ignored. The running search completes with the result for the request captured at its own start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (taken only when idle) |
| fin | input | 32 | Input clock frequency, Hz |
| freq_req | input | 32 | Requested serial clock rate, Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Request could not be served |
| div_a | output | 2 | First-stage divisor field |
| div_b | output | 6 | Second-stage divisor field (Bc - 1) |
| fout | output | 32 | Achieved serial clock rate, Hz |

## Verification
The assertions rely on the request being captured inside the block at `start`. They relate the result only to that captured copy, not to the live input ports, which the stimulus is free to change in mid-search.

The product check assumes the captured `fin` fits in 32 bits. It also assumes that the search only reaches a divide when the rate is at most 400 kHz, so every divisor product stays well inside 32 bits. The stimulus therefore spans 32-bit `fin` values up to all ones, and it includes out-of-range rates that must be refused before any division.

`start` is always driven as a single-cycle pulse away from the clock edge. This includes a deliberate pulse in mid-search carrying a different request.

// File: rtl/scl_search_pkg.sv
package scl_search_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RANGE,
        ST_BCEIL,
        ST_FREQ,
        ST_FINISH
    } search_st_e;

endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          run;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  quo;
        logic [W-1:0]  rem;
        logic [W-1:0]  den;
    } div_regs_t;

    div_regs_t r_d, r_q;
    logic [W:0] shifted;
    logic       fits;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        shifted  = {r_q.rem, r_q.quo[W-1]};
        fits     = (shifted >= {1'b0, r_q.den});
        if (go) begin
            r_d.run = 1'b1;
            r_d.cnt = CW'(W);
            r_d.quo = num;
            r_d.rem = '0;
            r_d.den = den;
        end else if (r_q.run) begin
            r_d.rem = fits ? W'(shifted - {1'b0, r_q.den}) : shifted[W-1:0];
            r_d.quo = {r_q.quo[W-2:0], fits};
            r_d.cnt = r_q.cnt - CW'(1);
            if (r_q.cnt == CW'(1)) begin
                r_d.run  = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done = r_q.done;
    assign quo  = r_q.quo;
    assign rem  = r_q.rem;

endmodule

// File: rtl/scl_div_search.sv
module scl_div_search
    import scl_search_pkg::*;
#(
    parameter int W        = 32,
    parameter int PRESCALE = 22,
    parameter int A_CNT    = 4,
    parameter int B_LIMIT  = 64,
    parameter int F_LIMIT  = 400000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [W-1:0]               fin,
    input  logic [W-1:0]               freq_req,
    output logic                       busy,
    output logic                       done,
    output logic                       err,
    output logic [$clog2(A_CNT)-1:0]   div_a,
    output logic [$clog2(B_LIMIT)-1:0] div_b,
    output logic [W-1:0]               fout
);
    localparam int AW = $clog2(A_CNT);
    localparam int BW = $clog2(B_LIMIT);
    localparam logic [W-1:0]  ONE    = W'(1);
    localparam logic [W-1:0]  K_PRE  = W'(PRESCALE);
    localparam logic [W-1:0]  F_MAX  = W'(F_LIMIT);
    localparam logic [W-1:0]  B_MAX  = W'(B_LIMIT);
    localparam logic [W-1:0]  R_MAX  = W'(A_CNT * B_LIMIT);
    localparam logic [AW-1:0] A_LAST = AW'(A_CNT - 1);

    typedef struct packed {
        search_st_e    st;
        logic [W-1:0]  fin;
        logic [W-1:0]  req;
        logic [AW-1:0] a;
        logic [W-1:0]  bc;
        logic          found;
        logic [AW-1:0] best_a;
        logic [BW-1:0] best_b;
        logic [W-1:0]  best_f;
        logic [W-1:0]  best_e;
        logic          done;
        logic          err;
        logic [AW-1:0] res_a;
        logic [BW-1:0] res_b;
        logic [W-1:0]  res_f;
    } srch_regs_t;

    srch_regs_t s_d, s_q;

    logic         div_go, div_done;
    logic [W-1:0] div_n, div_d, div_q, div_r;
    logic [W-1:0] a_now, a_next, bc_new;
    logic         advance;

    seq_divider #(.W(W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (div_n),
        .den  (div_d),
        .done (div_done),
        .quo  (div_q),
        .rem  (div_r)
    );

    always_comb begin
        s_d     = s_q;
        s_d.done = 1'b0;
        div_go  = 1'b0;
        div_n   = s_q.fin;
        div_d   = ONE;
        advance = 1'b0;
        a_now   = {{(W-AW){1'b0}}, s_q.a} + ONE;
        a_next  = a_now + ONE;
        bc_new  = div_q + {{(W-1){1'b0}}, |div_r};

        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.fin    = fin;
                    s_d.req    = freq_req;
                    s_d.a      = '0;
                    s_d.found  = 1'b0;
                    s_d.best_a = '0;
                    s_d.best_b = '0;
                    s_d.best_f = '0;
                    s_d.best_e = '1;
                    if (freq_req == '0 || freq_req > F_MAX) begin
                        s_d.st = ST_FINISH;
                    end else begin
                        div_go = 1'b1;
                        div_n  = fin;
                        div_d  = K_PRE * freq_req;
                        s_d.st = ST_RANGE;
                    end
                end
            end
            ST_RANGE: begin
                if (div_done) begin
                    if (div_q == '0 || div_q > R_MAX) begin
                        s_d.st = ST_FINISH;
                    end else begin
                        div_go = 1'b1;
                        div_d  = K_PRE * s_q.req;
                        s_d.st = ST_BCEIL;
                    end
                end
            end
            ST_BCEIL: begin
                if (div_done) begin
                    if (bc_new == '0 || bc_new > B_MAX) begin
                        advance = 1'b1;
                    end else begin
                        s_d.bc = bc_new;
                        div_go = 1'b1;
                        div_d  = K_PRE * a_now * bc_new;
                        s_d.st = ST_FREQ;
                    end
                end
            end
            ST_FREQ: begin
                if (div_done) begin
                    if (div_q <= s_q.req && (s_q.req - div_q) < s_q.best_e) begin
                        s_d.found  = 1'b1;
                        s_d.best_a = s_q.a;
                        s_d.best_b = BW'(s_q.bc - ONE);
                        s_d.best_f = div_q;
                        s_d.best_e = s_q.req - div_q;
                    end
                    advance = 1'b1;
                end
            end
            ST_FINISH: begin
                s_d.done  = 1'b1;
                s_d.err   = ~s_q.found;
                s_d.res_a = s_q.found ? s_q.best_a : '0;
                s_d.res_b = s_q.found ? s_q.best_b : '0;
                s_d.res_f = s_q.found ? s_q.best_f : '0;
                s_d.st    = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (advance) begin
            if (s_q.a == A_LAST) begin
                s_d.st = ST_FINISH;
            end else begin
                s_d.a  = s_q.a + AW'(1);
                div_go = 1'b1;
                div_d  = K_PRE * s_q.req * a_next;
                s_d.st = ST_BCEIL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    logic [W-1:0] req_lat, fin_lat;
    assign req_lat = s_q.req;
    assign fin_lat = s_q.fin;

    assign busy  = (s_q.st != ST_IDLE);
    assign done  = s_q.done;
    assign err   = s_q.err;
    assign div_a = s_q.res_a;
    assign div_b = s_q.res_b;
    assign fout  = s_q.res_f;

endmodule

// File: rtl/scl_search_checker.sv
module scl_search_checker #(
    parameter int W        = 32,
    parameter int AW       = 2,
    parameter int BW       = 6,
    parameter int PRESCALE = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [AW-1:0] div_a,
    input logic [BW-1:0] div_b,
    input logic [W-1:0]  fout,
    input logic [W-1:0]  req_q,
    input logic [W-1:0]  fin_q
);
    localparam int PW = 2 * W;
    logic [PW-1:0] scale, reach;

    always_comb begin
        scale = PW'(PRESCALE) * (PW'(div_a) + PW'(1)) * (PW'(div_b) + PW'(1));
        reach = PW'(fout) * scale;
    end

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (div_a == '0 && div_b == '0 && fout == '0));

    assert_rate_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (fout <= req_q && reach <= PW'(fin_q)));

    assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(req_q) && $stable(fin_q)));

endmodule

bind scl_div_search scl_search_checker #(
    .W(W), .AW(AW), .BW(BW), .PRESCALE(PRESCALE)
) u_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .err   (err),
    .div_a (div_a),
    .div_b (div_b),
    .fout  (fout),
    .req_q (req_lat),
    .fin_q (fin_lat)
);

// File: tb/test_scl_div_search.sv
module test_scl_div_search;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] fin = '0;
    logic [31:0] freq_req = '0;
    logic        busy, done, err;
    logic [1:0]  div_a;
    logic [5:0]  div_b;
    logic [31:0] fout;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_div_search i_scl_div_search (
        .clk(clk), .rst_n(rst_n), .start(start), .fin(fin), .freq_req(freq_req),
        .busy(busy), .done(done), .err(err), .div_a(div_a), .div_b(div_b), .fout(fout)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // kind: 0 success, 3 bad rate, 4 ratio out of range, 6 no candidate
    task automatic model(input longint f_in, input longint req, output int kind,
                         output int ea, output int eb, output longint ef);
        longint best_e;
        kind = 0; ea = 0; eb = 0; ef = 0;
        if (req == 0 || req > 400000) begin kind = 3; return; end
        if ((f_in / (22 * req)) == 0 || (f_in / (22 * req)) > 256) begin kind = 4; return; end
        best_e = 64'h7fff_ffff_ffff_ffff;
        kind = 6;
        for (int a = 0; a < 4; a++) begin
            longint den, bc, f;
            den = 22 * req * (a + 1);
            bc  = (f_in + den - 1) / den;
            if (bc < 1 || bc > 64) continue;
            f = f_in / (22 * (a + 1) * bc);
            if (f > req) continue;
            if (req - f < best_e) begin
                best_e = req - f; kind = 0; ea = a; eb = int'(bc - 1); ef = f;
            end
        end
    endtask

    task automatic pulse_start(input longint f_in, input longint req);
        @(negedge clk);
        fin = f_in[31:0]; freq_req = req[31:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", longint'(busy), 1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        chk(done == 1'b1, "R2", "done seen", longint'(done), 1);
        chk(busy == 1'b0, "R2", "busy low with done", longint'(busy), 0);
    endtask

    task automatic compare(input longint f_in, input longint req);
        int kind, ea, eb;
        longint ef;
        string tag;
        model(f_in, req, kind, ea, eb, ef);
        case (kind)
            3: tag = "R3";
            4: tag = "R4";
            6: tag = "R6";
            default: tag = "R5";
        endcase
        chk(err == (kind != 0), tag, "err", longint'(err), longint'(kind != 0));
        if (kind != 0) begin
            chk(div_a == 0 && div_b == 0 && fout == 0, "R6", "zero outputs on error",
                longint'({div_a, div_b}) + longint'(fout), 0);
        end else begin
            chk(div_a == ea[1:0], "R5", "div_a", longint'(div_a), longint'(ea));
            chk(div_b == eb[5:0], "R5", "div_b", longint'(div_b), longint'(eb));
            chk(fout == ef[31:0], "R5", "fout", longint'(fout), ef);
            chk(longint'(fout) * 22 * (longint'(div_a) + 1) * (longint'(div_b) + 1) <= f_in,
                "R7", "rate product", longint'(fout), ef);
        end
        @(negedge clk);
        chk(done == 1'b0, "R2", "done single cycle", longint'(done), 0);
    endtask

    task automatic run(input longint f_in, input longint req);
        pulse_start(f_in, req);
        wait_done();
        compare(f_in, req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        longint fins [8] = '{100000000, 50000000, 33333333, 12000000,
                             1000000, 100000, 1000, 64'hFFFF_FFFF};
        longint reqs [13] = '{0, 1, 100, 1000, 5000, 10000, 50000,
                              100000, 100001, 200000, 400000, 400001, 1000000};
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(busy == 0 && done == 0 && err == 0, "R1", "control outputs",
            longint'({busy, done, err}), 0);
        chk(div_a == 0 && div_b == 0 && fout == 0, "R1", "result outputs",
            longint'(fout) + longint'({div_a, div_b}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (fins[i]) begin
            foreach (reqs[j]) run(fins[i], reqs[j]);
            for (longint r = 1000; r <= 400000; r += 20011) run(fins[i], r);
        end

        // R8: start while busy carries another request and must be ignored
        pulse_start(100000000, 100000);
        repeat (5) @(negedge clk);
        fin = 32'd1000; freq_req = 32'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8", "still busy", longint'(busy), 1);
        wait_done();
        compare(100000000, 100000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule